// File: doc/BRIEF.md
# Memory-Domain Association Table with Column Locks

This block holds, for each requester ID, a bitmap of the memory domains that requester may reach. Software reads and writes each requester's bitmap as two 32-bit words through a simple host port. A lookup port takes a requester ID and returns that requester's full domain bitmap one cycle later, so an access checker can use it.

Each domain column can be write-protected. A lock bit for domain m freezes bit m in the row of every requester, not just in one row. The 63 lock bits are spread over two 32-bit lock registers. A sticky freeze bit in the low lock register makes both lock registers read-only until the next reset. Lock bits can only be set by software, never cleared.

The host port is served by a two-state machine:
- `H_IDLE` is the state with no read response pending.
- `H_RESP` presents read data for one cycle.
- `H_IDLE -> H_RESP` on an accepted read.
- `H_RESP -> H_RESP` on a back-to-back read.
- `H_RESP -> H_IDLE` when no read is accepted.

Top module: `mdlk_table`

## Requirements
- R1: After reset, every association row, every lock bit and the freeze bit are zero, and `host_rvalid` and `lk_valid` are low.
- R2: A read accepted on one clock edge (`host_valid`=1, `host_write`=0) raises `host_rvalid` for exactly the following cycle with the addressed word on `host_rdata`. An address outside the map reads as zero.
- R3: A write to a row word updates only the bits whose domain lock is clear. Locked bits keep their old value, in every requester's row.
- R4: Layout of the low lock register (address 0): bit 0 is the freeze bit, and bit m+1 is the lock for domain m (m = 0..30). Layout of the high lock register (address 1): bit k is the lock for domain 31+k (k = 0..31).
- R5: Writing 0 to a lock bit has no effect. Lock bits only go from 0 to 1.
- R6: Once the freeze bit is 1, writes to both lock registers are ignored until reset. A write that sets the freeze bit still applies the lock bits it carries.
- R7: Row bits and lock bits for domains at or above `NUM_MD` read as zero and cannot be set.
- R8: A lookup request raises `lk_valid` in the next cycle, with the requester's bitmap on `lk_map` (bit m = domain m).
- R9: A lookup of a requester ID at or above `NUM_RID` returns all zeros.
- R10: Row s has its domains 0..31 at address 2+2s (bit m = domain m) and its domains 32..62 at address 3+2s (bit k = domain 32+k, bit 31 reads zero). Writes outside the map change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W = $clog2(2+2*NUM_RID) | Word address |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| lk_req | input | 1 | Lookup request |
| lk_rid | input | RID_W | Requester ID to look up |
| lk_valid | output | 1 | Lookup result valid |
| lk_map | output | NUM_MD | Domain bitmap of the requester |

## Verification
The bench goes after several corner cases, each with a distinct failure it would expose:
- A row write that straddles locked and unlocked columns in two different rows. A per-row or whole-word lock would overwrite the protected bits or drop the free ones.
- Lock bits written back as zero. A design that replaces the lock register instead of OR-ing into it would unlock columns.
- Writes after the freeze bit is set, and the write that sets the freeze bit together with fresh lock bits. A design that freezes too early loses those bits, and one that ignores the freeze keeps accepting locks.
- Domain bits above a reduced `NUM_MD`, an out-of-range lookup ID and addresses past the last row. A design that gets these wrong leaks nonzero data.

// File: rtl/mdlk_pkg.sv
package mdlk_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_MD   = 63;
    localparam int ROW_BASE = 2;

    typedef logic [MAX_MD-1:0] md_vec_t;

    typedef enum logic {
        H_IDLE,
        H_RESP
    } host_state_e;

    // bit m set for every implemented domain m < n
    function automatic md_vec_t impl_mask(int n);
        md_vec_t v;
        v = '0;
        for (int m = 0; m < MAX_MD; m++) begin
            if (m < n) v[m] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/mdlk_lock_reg.sv
module mdlk_lock_reg
    import mdlk_pkg::*;
#(
    parameter int NUM_MD = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output md_vec_t           lock_q,
    output logic              frozen_q
);

    localparam md_vec_t MASK = impl_mask(NUM_MD);

    md_vec_t set_v;

    always_comb begin
        set_v = '0;
        if (wr_lo) set_v[30:0]  = wdata[31:1];
        if (wr_hi) set_v[62:31] = wdata;
        set_v = set_v & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q   <= '0;
            frozen_q <= 1'b0;
        end else if (!frozen_q) begin
            lock_q <= lock_q | set_v;
            if (wr_lo && wdata[0]) frozen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/mdlk_assoc_row.sv
module mdlk_assoc_row
    import mdlk_pkg::*;
#(
    parameter int NUM_MD = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  md_vec_t           lock,
    output md_vec_t           row_q
);

    localparam md_vec_t MASK = impl_mask(NUM_MD);

    md_vec_t upd;
    md_vec_t wmask;

    always_comb begin
        upd   = {wdata[30:0], wdata};
        wmask = {{31{wr_hi}}, {32{wr_lo}}} & ~lock & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= (row_q & ~wmask) | (upd & wmask);
    end

endmodule

// File: rtl/mdlk_lookup.sv
module mdlk_lookup
    import mdlk_pkg::*;
#(
    parameter int NUM_RID = 16,
    parameter int RID_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [RID_W-1:0] rid,
    input  md_vec_t          rows [NUM_RID],
    output logic             valid_q,
    output md_vec_t          map_q
);

    md_vec_t pick;

    always_comb begin
        pick = '0;
        for (int r = 0; r < NUM_RID; r++) begin
            if (rid == RID_W'(r)) pick = rows[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            map_q   <= '0;
        end else begin
            valid_q <= req;
            if (req) map_q <= pick;
        end
    end

endmodule

// File: rtl/mdlk_table.sv
module mdlk_table
    import mdlk_pkg::*;
#(
    parameter int NUM_RID = 16,
    parameter int NUM_MD  = 63,
    parameter int RID_W   = 8,
    localparam int ADDR_W = $clog2(ROW_BASE + 2 * NUM_RID)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              lk_req,
    input  logic [RID_W-1:0]  lk_rid,
    output logic              lk_valid,
    output logic [NUM_MD-1:0] lk_map
);

    localparam int ROW_END = ROW_BASE + 2 * NUM_RID;

    host_state_e       state_q, state_d;
    logic [WORD_W-1:0] rdata_q, rd_word;
    logic              wr_en, rd_en, is_lo, is_hi, is_row;
    logic [ADDR_W-1:0] row_off;
    md_vec_t           lock_q;
    logic              sticky_q;
    md_vec_t           row_q [NUM_RID];
    md_vec_t           map_full;

    // ---------------- address decode ----------------
    always_comb begin
        wr_en   = host_valid && host_write;
        rd_en   = host_valid && !host_write;
        is_lo   = (32'(host_addr) == 0);
        is_hi   = (32'(host_addr) == 1);
        is_row  = (32'(host_addr) >= ROW_BASE) && (32'(host_addr) < ROW_END);
        row_off = host_addr - ADDR_W'(ROW_BASE);
    end

    // ---------------- lock registers ----------------
    mdlk_lock_reg #(.NUM_MD(NUM_MD)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo    (wr_en && is_lo),
        .wr_hi    (wr_en && is_hi),
        .wdata    (host_wdata),
        .lock_q   (lock_q),
        .frozen_q (sticky_q)
    );

    // ---------------- association rows ----------------
    for (genvar r = 0; r < NUM_RID; r++) begin : g_row
        logic sel;
        assign sel = wr_en && is_row && (row_off[ADDR_W-1:1] == (ADDR_W-1)'(r));
        mdlk_assoc_row #(.NUM_MD(NUM_MD)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (sel && !row_off[0]),
            .wr_hi (sel && row_off[0]),
            .wdata (host_wdata),
            .lock  (lock_q),
            .row_q (row_q[r])
        );
    end

    // ---------------- read mux ----------------
    always_comb begin
        rd_word = '0;
        if (is_lo) begin
            rd_word = {lock_q[30:0], sticky_q};
        end else if (is_hi) begin
            rd_word = lock_q[62:31];
        end else if (is_row) begin
            for (int r = 0; r < NUM_RID; r++) begin
                if (row_off[ADDR_W-1:1] == (ADDR_W-1)'(r)) begin
                    rd_word = row_off[0] ? {1'b0, row_q[r][62:32]} : row_q[r][31:0];
                end
            end
        end
    end

    // ---------------- host FSM: next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: if (rd_en)  state_d = H_RESP;
            H_RESP: if (!rd_en) state_d = H_IDLE;
            default:            state_d = H_IDLE;
        endcase
    end

    // ---------------- host FSM: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- host FSM: outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
    end

    assign host_rvalid = (state_q == H_RESP);
    assign host_rdata  = host_rvalid ? rdata_q : '0;

    // ---------------- lookup ----------------
    mdlk_lookup #(.NUM_RID(NUM_RID), .RID_W(RID_W)) u_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (lk_req),
        .rid     (lk_rid),
        .rows    (row_q),
        .valid_q (lk_valid),
        .map_q   (map_full)
    );

    assign lk_map = map_full[NUM_MD-1:0];

    if (NUM_MD < MAX_MD) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^map_full[MAX_MD-1:NUM_MD];
    end

endmodule

// File: rtl/mdlk_table_chk.sv
module mdlk_table_chk
    import mdlk_pkg::*;
#(
    parameter int NUM_RID = 16,
    parameter int NUM_MD  = 63,
    parameter int RID_W   = 8,
    parameter int ADDR_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_write,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_rvalid,
    input logic              lk_req,
    input logic [RID_W-1:0]  lk_rid,
    input logic              lk_valid,
    input logic [NUM_MD-1:0] lk_map,
    input md_vec_t           lock_q,
    input logic              sticky_q,
    input md_vec_t           rows [NUM_RID]
);

    localparam md_vec_t MASK = impl_mask(NUM_MD);

    a_r2_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && !host_write |=> host_rvalid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && !host_write) |=> !host_rvalid);

    a_r5_lock_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) & ~lock_q) == '0);

    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_q |=> sticky_q);

    a_r6_frozen_locks: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_q && host_valid && host_write && (32'(host_addr) < 2) |=> $stable(lock_q));

    a_r7_no_high_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~MASK) == '0);

    a_r8_lookup_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    a_r8_lookup_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);

    a_r9_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && (32'(lk_rid) >= NUM_RID) |=> lk_map == '0);

    for (genvar r = 0; r < NUM_RID; r++) begin : g_rowchk
        a_r3_locked_column: assert property (@(posedge clk) disable iff (!rst_n)
            ((rows[r] ^ $past(rows[r])) & $past(lock_q)) == '0);

        a_r7_no_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (rows[r] & ~MASK) == '0);
    end

endmodule

bind mdlk_table mdlk_table_chk #(
    .NUM_RID (NUM_RID),
    .NUM_MD  (NUM_MD),
    .RID_W   (RID_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .lk_req      (lk_req),
    .lk_rid      (lk_rid),
    .lk_valid    (lk_valid),
    .lk_map      (lk_map),
    .lock_q      (lock_q),
    .sticky_q    (sticky_q),
    .rows        (row_q)
);

// File: tb/sim_mdlk_table.sv
`timescale 1ns/1ps
module sim_mdlk_table;

    localparam int NRID   = 8;
    localparam int NMD    = 40;
    localparam int RIDW   = 4;
    localparam int ADDR_W = $clog2(2 + 2 * NRID);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_valid = 1'b0;
    logic              host_write = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_rvalid;
    logic [31:0]       host_rdata;
    logic              lk_req = 1'b0;
    logic [RIDW-1:0]   lk_rid = '0;
    logic              lk_valid;
    logic [NMD-1:0]    lk_map;

    always #2 clk = ~clk;

    mdlk_table #(.NUM_RID(NRID), .NUM_MD(NMD), .RID_W(RIDW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .lk_req(lk_req), .lk_rid(lk_rid),
        .lk_valid(lk_valid), .lk_map(lk_map)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // ---------------- reference model (from the requirements) ----------------
    logic [62:0] mlock;
    logic        mfreeze;
    logic [62:0] mrow [NRID];
    logic [62:0] mmask;

    typedef struct {
        logic [62:0] val;
        string       tag;
    } exp_t;

    exp_t rq[$];
    exp_t lq[$];

    task automatic check(input bit ok, input string tag, input logic [62:0] act, input logic [62:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mlock = '0;
        mfreeze = 1'b0;
        for (int r = 0; r < NRID; r++) mrow[r] = '0;
    endtask

    function automatic logic [31:0] model_read(input int a);
        if (a == 0) return {mlock[30:0], mfreeze};
        if (a == 1) return mlock[62:31];
        if (a >= 2 && a < 2 + 2 * NRID) begin
            if (a % 2 == 0) return mrow[(a - 2) / 2][31:0];
            return {1'b0, mrow[(a - 2) / 2][62:32]};
        end
        return '0;
    endfunction

    task automatic model_write(input int a, input logic [31:0] w);
        logic [62:0] wm, upd;
        if (a == 0 && !mfreeze) begin
            mlock[30:0] = mlock[30:0] | (w[31:1] & mmask[30:0]);
            mfreeze = mfreeze | w[0];
        end else if (a == 1 && !mfreeze) begin
            mlock[62:31] = mlock[62:31] | (w & mmask[62:31]);
        end else if (a >= 2 && a < 2 + 2 * NRID) begin
            wm  = (a % 2 == 0) ? {31'd0, {32{1'b1}}} : {{31{1'b1}}, 32'd0};
            wm  = wm & ~mlock & mmask;
            upd = {w[30:0], w};
            mrow[(a - 2) / 2] = (mrow[(a - 2) / 2] & ~wm) | (upd & wm);
        end
    endtask

    // ---------------- driver ----------------
    task automatic idle();
        @(negedge clk);
        host_valid = 1'b0;
        host_write = 1'b0;
        lk_req = 1'b0;
    endtask

    task automatic hwrite(input int a, input logic [31:0] w);
        @(negedge clk);
        host_valid = 1'b1;
        host_write = 1'b1;
        host_addr  = ADDR_W'(a);
        host_wdata = w;
        lk_req     = 1'b0;
        model_write(a, w);
    endtask

    task automatic hread(input int a, input string tag);
        exp_t e;
        @(negedge clk);
        host_valid = 1'b1;
        host_write = 1'b0;
        host_addr  = ADDR_W'(a);
        lk_req     = 1'b0;
        e.val = {31'd0, model_read(a)};
        e.tag = tag;
        rq.push_back(e);
    endtask

    task automatic lookup(input int rid, input string tag);
        exp_t e;
        @(negedge clk);
        host_valid = 1'b0;
        lk_req = 1'b1;
        lk_rid = RIDW'(rid);
        e.val = (rid < NRID) ? (mrow[rid] & mmask) : '0;
        e.tag = tag;
        lq.push_back(e);
    endtask

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (rq.size() == 0) check(1'b0, "R2 unexpected rvalid", 63'(host_rdata), '0);
            else begin
                exp_t e;
                e = rq.pop_front();
                check(host_rdata == e.val[31:0], e.tag, 63'(host_rdata), e.val);
            end
        end
        if (rst_n && lk_valid) begin
            if (lq.size() == 0) check(1'b0, "R8 unexpected lk_valid", 63'(lk_map), '0);
            else begin
                exp_t e;
                e = lq.pop_front();
                check(63'(lk_map) == e.val, e.tag, 63'(lk_map), e.val);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int m = 0; m < 63; m++) mmask[m] = (m < NMD);
        model_reset();
        repeat (3) @(negedge clk);
        check(host_rvalid == 1'b0, "R1 rvalid at reset", 63'(host_rvalid), '0);
        check(lk_valid == 1'b0, "R1 lk_valid at reset", 63'(lk_valid), '0);
        rst_n = 1'b1;

        // R1: everything reads zero after reset
        hread(0, "R1 lock low reset");
        hread(1, "R1 lock high reset");
        hread(2, "R1 row0 low reset");
        hread(17, "R1 row7 high reset");

        // R10 / R7: fill rows, read back, unimplemented domains zero
        hwrite(2, 32'hFFFF_FFFF);
        hwrite(3, 32'hFFFF_FFFF);
        hwrite(8, 32'hA5A5_5A5A);
        hwrite(9, 32'h0000_00C3);
        hread(2, "R10 row0 low");
        hread(3, "R7 row0 high masked above NUM_MD");
        hread(8, "R10 row3 low");
        hread(9, "R10 row3 high");

        // R4 / R7: set locks on domains 1, 5 (low) and 31, 34, 51 (high)
        hwrite(0, (32'd1 << 2) | (32'd1 << 6));
        hwrite(1, (32'd1 << 0) | (32'd1 << 3) | (32'd1 << 20));
        hread(0, "R4 lock low layout");
        hread(1, "R4 R7 lock high layout");

        // R3: locked columns hold in every row
        hwrite(2, 32'h0000_0000);
        hwrite(3, 32'h0000_0000);
        hwrite(8, 32'hFFFF_FFFF);
        hwrite(9, 32'hFFFF_FFFF);
        hread(2, "R3 row0 low locked cols");
        hread(3, "R3 row0 high locked cols");
        hread(8, "R3 row3 low locked cols");
        hread(9, "R3 row3 high locked cols");

        // R5: zero writes do not clear locks
        hwrite(0, 32'h0);
        hwrite(1, 32'h0);
        hread(0, "R5 lock low kept");
        hread(1, "R5 lock high kept");

        // R6: freeze with a new lock in the same write, then further writes ignored
        hwrite(0, 32'h1 | (32'd1 << 3));
        hwrite(0, 32'd1 << 4);
        hwrite(1, 32'hFFFF_FFFF);
        hread(0, "R6 freeze write applied, later ignored");
        hread(1, "R6 lock high frozen");

        // R10: out-of-map accesses
        hwrite(20, 32'hFFFF_FFFF);
        hread(20, "R10 out-of-map read zero");
        hread(31, "R2 out-of-map read zero");
        hread(16, "R10 row7 untouched");

        // R8 / R9: lookups, including back-to-back and out of range
        lookup(0, "R8 lookup rid0");
        lookup(3, "R8 lookup rid3");
        lookup(7, "R8 lookup rid7");
        lookup(9, "R9 lookup out of range");
        lookup(15, "R9 lookup out of range max");
        idle();
        idle();
        idle();

        // R1 / R6: a new reset clears locks and the freeze bit
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hread(0, "R1 R6 lock low cleared by reset");
        hwrite(0, 32'd1 << 2);
        hread(0, "R6 locks writable after reset");
        idle();
        idle();
        idle();

        check(rq.size() == 0, "R2 all reads answered", 63'(rq.size()), '0);
        check(lq.size() == 0, "R8 all lookups answered", 63'(lq.size()), '0);
        finish_run();
    end

endmodule